// File: doc/BRIEF.md
# SMBus Target Protocol Engine

This block sits on the target side of a two-wire serial bus, above a byte-level front end that has already handled bit timing and address matching. The front end reports bus events as single-cycle pulses: a start in write direction, a start in read direction, a stop, a NACK from the controller, each received data byte, and each request for a byte to send back. The engine tracks where the current transaction stands and, once the transaction's shape is known, raises one strobe toward a register-style backend: a quick command with its direction, a send-byte, a receive-byte request, a command write carrying the payload, or an indexed command read.

Word writes and block writes look the same on the wire. The engine therefore holds every byte written in a 34-entry capture store and decides the transaction type only when a stop or a repeated start ends the write phase. The decision is based on how many bytes arrived. The backend reads the payload out of the store through an index port. For reads, the engine passes along the command byte and a running byte index, and the backend chooses what each index means.

Top module: `smbt_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, tx_valid, be_quick, be_send, be_wr, ovf and confused are all 0.
- R2: A stop after a write-direction start with no bytes received pulses be_quick for one cycle with be_quick_rd = 0. A stop after a read-direction start, given from idle and with no byte yet read, pulses be_quick with be_quick_rd = 1.
- R3: A stop after a write-direction start and exactly one received byte pulses be_send, and be_send_byte carries that byte.
- R4: A stop after N ≥ 2 received bytes pulses be_wr with be_wr_cmd = first byte and be_wr_len = N−1. Driving be_buf_idx = k puts payload byte k, which is the (k+2)-th received byte, on be_buf_byte combinationally.
- R5: After a read-direction start from idle, the first rd_req raises be_recv_req in the same cycle. In the next cycle tx_valid = 1 and tx_byte equals be_recv_data.
- R6: A read-direction start after 1 or more written bytes latches the first byte as the command. If 2 or more bytes were written, be_wr is first dispatched exactly as in R4. Each later rd_req raises be_rd_req with be_rd_cmd = command and be_rd_idx = 0, 1, 2, … and returns be_rd_data on tx_byte in the next cycle.
- R7: A controller NACK during a command read ends the read, and any later rd_req returns 0x00 without a backend request. A NACK after a read has ended is ignored. A NACK in any other state makes confused = 1.
- R8: A write-direction start outside idle, or a read-direction start after a write-direction start with no bytes received, makes confused = 1.
- R9: At most 34 bytes are stored. Bytes beyond that are dropped and set ovf. ovf stays set until the next stop, which clears it. The resulting dispatch reports be_wr_len = 33.
- R10: While confused, received bytes, NACKs and starts change nothing, and rd_req returns 0x00. A stop returns the engine to idle with confused = 0 and no dispatch strobe.
- R11: Bytes received outside the write phase are not stored and do not count toward the byte total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start_wr | input | 1 | Start (or repeated start) in write direction |
| ev_start_rd | input | 1 | Start (or repeated start) in read direction |
| ev_stop | input | 1 | Stop condition |
| ev_nack | input | 1 | Controller NACKed the last byte sent |
| rx_valid | input | 1 | A data byte was received |
| rx_byte | input | 8 | Received data byte |
| rd_req | input | 1 | Front end needs a byte to transmit |
| tx_valid | output | 1 | tx_byte is valid (one cycle after rd_req) |
| tx_byte | output | 8 | Byte to transmit |
| be_quick | output | 1 | Quick-command strobe |
| be_quick_rd | output | 1 | Quick-command direction, 1 = read |
| be_send | output | 1 | Send-byte strobe |
| be_send_byte | output | 8 | Send-byte value |
| be_wr | output | 1 | Command-write strobe |
| be_wr_cmd | output | 8 | Command byte of the write |
| be_wr_len | output | 8 | Payload byte count of the write |
| be_buf_idx | input | 8 | Payload index requested by the backend |
| be_buf_byte | output | 8 | Payload byte at be_buf_idx |
| be_recv_req | output | 1 | Receive-byte request (combinational) |
| be_recv_data | input | 8 | Backend answer to be_recv_req |
| be_rd_req | output | 1 | Indexed command-read request (combinational) |
| be_rd_cmd | output | 8 | Command for the read |
| be_rd_idx | output | 8 | Byte index within the read |
| be_rd_data | input | 8 | Backend answer to be_rd_req |
| ovf | output | 1 | Capture store overflowed in this transaction |
| confused | output | 1 | Engine saw an out-of-order event |

## Verification
The assertions assume that the front end raises at most one of the six event inputs in any cycle. They also assume that the backend answers be_recv_req and be_rd_req combinationally within the same cycle. The bench drives each event as an isolated one-cycle pulse on the falling edge, so both assumptions hold throughout. The backend model is a pure function of the command and index. The bench sweeps write lengths from 0 to 37 bytes, every combination of 1–3 written bytes with 1–4 read bytes, and each out-of-order event path.

// File: rtl/smbt_pkg.sv
// Shared types for the SMBus target protocol engine.
package smbt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // no transaction open
        ST_WR   = 3'd1,  // collecting written bytes
        ST_RCV  = 3'd2,  // read start from idle, nothing read yet
        ST_RD   = 3'd3,  // indexed command read in progress
        ST_DONE = 3'd4,  // read finished, waiting for stop
        ST_CONF = 3'd5   // out-of-order event seen, waiting for stop
    } smbt_state_e;
endpackage

// File: rtl/smbt_capture.sv
// Capture store for written bytes.
// Holds up to DEPTH bytes, written by index. Offers a fixed read of entry 0
// (the command byte) and a random read port for the backend.
// Assumes the writer never presents an index >= DEPTH.
module smbt_capture #(
    parameter int DEPTH = 34,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_ptr,
    input  logic [7:0]       wr_data,
    input  logic [CNT_W-1:0] rd_idx,
    output logic [7:0]       head,
    output logic [7:0]       rd_data
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [7:0] mem [DEPTH];

    // Storage write with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_ptr[IDX_W-1:0]] <= wr_data;
        end
    end

    // Read ports; out-of-range backend index reads as zero.
    always_comb begin
        head    = mem[0];
        rd_data = (rd_idx < DEPTH_C) ? mem[rd_idx[IDX_W-1:0]] : 8'h00;
    end

    p_cap_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_ptr < DEPTH_C));
endmodule

// File: rtl/smbt_ctrl.sv
// Transaction state machine for the SMBus target engine.
// Tracks the transaction phase, counts bytes, classifies the transaction
// when the write phase ends, and drives registered dispatch strobes plus
// combinational read requests to the backend.
// Assumes at most one event input is high per cycle and a backend that
// answers read requests within the same cycle.
module smbt_ctrl
    import smbt_pkg::*;
#(
    parameter int DEPTH = 34,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_start_wr,
    input  logic             ev_start_rd,
    input  logic             ev_stop,
    input  logic             ev_nack,
    input  logic             rx_valid,
    input  logic             rd_req,
    input  logic [7:0]       cap_head,
    output logic             cap_wr_en,
    output logic [CNT_W-1:0] cap_wr_ptr,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    output logic             be_quick,
    output logic             be_quick_rd,
    output logic             be_send,
    output logic [7:0]       be_send_byte,
    output logic             be_wr,
    output logic [7:0]       be_wr_cmd,
    output logic [CNT_W-1:0] be_wr_len,
    output logic             be_recv_req,
    input  logic [7:0]       be_recv_data,
    output logic             be_rd_req,
    output logic [7:0]       be_rd_cmd,
    output logic [CNT_W-1:0] be_rd_idx,
    input  logic [7:0]       be_rd_data,
    output logic             ovf,
    output logic             confused
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    smbt_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       cmd;
    logic             full;

    // Combinational capture control and backend read requests.
    always_comb begin
        full        = (cnt >= DEPTH_C);
        cap_wr_en   = rx_valid && (state == ST_WR) && !full;
        cap_wr_ptr  = cnt;
        be_recv_req = rd_req && (state == ST_RCV);
        be_rd_req   = rd_req && (state == ST_RD);
        be_rd_cmd   = cmd;
        be_rd_idx   = cnt;
        confused    = (state == ST_CONF);
    end

    // Main state, counters and registered dispatch strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cnt          <= '0;
            cmd          <= '0;
            ovf          <= 1'b0;
            tx_valid     <= 1'b0;
            tx_byte      <= '0;
            be_quick     <= 1'b0;
            be_quick_rd  <= 1'b0;
            be_send      <= 1'b0;
            be_send_byte <= '0;
            be_wr        <= 1'b0;
            be_wr_cmd    <= '0;
            be_wr_len    <= '0;
        end else begin
            be_quick <= 1'b0;
            be_send  <= 1'b0;
            be_wr    <= 1'b0;
            tx_valid <= 1'b0;
            if (ev_start_wr) begin
                state <= (state == ST_IDLE) ? ST_WR : ST_CONF;
            end else if (ev_start_rd) begin
                case (state)
                    ST_IDLE: state <= ST_RCV;
                    ST_WR: begin
                        if (cnt == '0) begin
                            state <= ST_CONF;
                        end else begin
                            cmd <= cap_head;
                            if (cnt > ONE_C) begin
                                be_wr     <= 1'b1;
                                be_wr_cmd <= cap_head;
                                be_wr_len <= cnt - ONE_C;
                            end
                            cnt   <= '0;
                            state <= ST_RD;
                        end
                    end
                    default: state <= ST_CONF;
                endcase
            end else if (ev_stop) begin
                case (state)
                    ST_WR: begin
                        if (cnt == '0) begin
                            be_quick    <= 1'b1;
                            be_quick_rd <= 1'b0;
                        end else if (cnt == ONE_C) begin
                            be_send      <= 1'b1;
                            be_send_byte <= cap_head;
                        end else begin
                            be_wr     <= 1'b1;
                            be_wr_cmd <= cap_head;
                            be_wr_len <= cnt - ONE_C;
                        end
                    end
                    ST_RCV: begin
                        be_quick    <= 1'b1;
                        be_quick_rd <= 1'b1;
                    end
                    default: ;
                endcase
                state <= ST_IDLE;
                cnt   <= '0;
                ovf   <= 1'b0;
            end else if (ev_nack) begin
                case (state)
                    ST_RD:   state <= ST_DONE;
                    ST_DONE: ;
                    default: state <= ST_CONF;
                endcase
            end else if (rx_valid) begin
                if (state == ST_WR) begin
                    if (full) ovf <= 1'b1;
                    else      cnt <= cnt + ONE_C;
                end
            end else if (rd_req) begin
                tx_valid <= 1'b1;
                case (state)
                    ST_RCV: begin
                        tx_byte <= be_recv_data;
                        state   <= ST_DONE;
                    end
                    ST_RD: begin
                        tx_byte <= be_rd_data;
                        cnt     <= cnt + ONE_C;
                    end
                    default: begin
                        tx_byte <= 8'h00;
                        state   <= ST_CONF;
                    end
                endcase
            end
        end
    end

    p_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_start_wr, ev_start_rd, ev_stop, ev_nack, rx_valid, rd_req}));
    p_one_dispatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({be_quick, be_send, be_wr}));
    p_dispatch_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (be_quick || be_send || be_wr) |-> $past(ev_stop || ev_start_rd));
    p_tx_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> tx_valid);
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ev_stop) |=> ovf);
    p_confused_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (confused && ev_stop) |=> !confused);
endmodule

// File: rtl/smbt_engine.sv
// SMBus target protocol engine, top level.
// Joins the transaction state machine to the capture store. Backend payload
// index k maps to capture entry k+1, because entry 0 is the command byte.
// Assumes a byte-level front end that issues one event per cycle.
module smbt_engine #(
    parameter int DEPTH = 34,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_start_wr,
    input  logic             ev_start_rd,
    input  logic             ev_stop,
    input  logic             ev_nack,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rd_req,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    output logic             be_quick,
    output logic             be_quick_rd,
    output logic             be_send,
    output logic [7:0]       be_send_byte,
    output logic             be_wr,
    output logic [7:0]       be_wr_cmd,
    output logic [CNT_W-1:0] be_wr_len,
    input  logic [CNT_W-1:0] be_buf_idx,
    output logic [7:0]       be_buf_byte,
    output logic             be_recv_req,
    input  logic [7:0]       be_recv_data,
    output logic             be_rd_req,
    output logic [7:0]       be_rd_cmd,
    output logic [CNT_W-1:0] be_rd_idx,
    input  logic [7:0]       be_rd_data,
    output logic             ovf,
    output logic             confused
);
    logic             cap_wr_en;
    logic [CNT_W-1:0] cap_wr_ptr;
    logic [7:0]       cap_head;
    logic [CNT_W-1:0] cap_rd_idx;

    // Payload index skips the command entry.
    always_comb cap_rd_idx = be_buf_idx + CNT_W'(1);

    smbt_capture #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cap_wr_en),
        .wr_ptr  (cap_wr_ptr),
        .wr_data (rx_byte),
        .rd_idx  (cap_rd_idx),
        .head    (cap_head),
        .rd_data (be_buf_byte)
    );

    smbt_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_start_wr  (ev_start_wr),
        .ev_start_rd  (ev_start_rd),
        .ev_stop      (ev_stop),
        .ev_nack      (ev_nack),
        .rx_valid     (rx_valid),
        .rd_req       (rd_req),
        .cap_head     (cap_head),
        .cap_wr_en    (cap_wr_en),
        .cap_wr_ptr   (cap_wr_ptr),
        .tx_valid     (tx_valid),
        .tx_byte      (tx_byte),
        .be_quick     (be_quick),
        .be_quick_rd  (be_quick_rd),
        .be_send      (be_send),
        .be_send_byte (be_send_byte),
        .be_wr        (be_wr),
        .be_wr_cmd    (be_wr_cmd),
        .be_wr_len    (be_wr_len),
        .be_recv_req  (be_recv_req),
        .be_recv_data (be_recv_data),
        .be_rd_req    (be_rd_req),
        .be_rd_cmd    (be_rd_cmd),
        .be_rd_idx    (be_rd_idx),
        .be_rd_data   (be_rd_data),
        .ovf          (ovf),
        .confused     (confused)
    );
endmodule

// File: tb/sim_smbt_engine.sv
// Self-checking bench for the SMBus target engine.
module sim_smbt_engine;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_start_wr = 0, ev_start_rd = 0, ev_stop = 0, ev_nack = 0;
    logic       rx_valid = 0, rd_req = 0;
    logic [7:0] rx_byte = '0;
    logic [7:0] be_buf_idx = '0;
    logic       tx_valid, be_quick, be_quick_rd, be_send, be_wr;
    logic [7:0] tx_byte, be_send_byte, be_wr_cmd, be_wr_len, be_buf_byte;
    logic       be_recv_req, be_rd_req, ovf, confused;
    logic [7:0] be_rd_cmd, be_rd_idx, be_rd_data;
    logic [7:0] be_recv_data = 8'h5A;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Backend model: read data is a pure function of command and index.
    function automatic logic [7:0] rd_fn(input logic [7:0] c, input logic [7:0] i);
        return c + 8'(i * 3) + 8'h21;
    endfunction
    assign be_rd_data = rd_fn(be_rd_cmd, be_rd_idx);

    function automatic logic [7:0] pat(input int n, input int k);
        return 8'(n * 7 + k * 13 + 1);
    endfunction

    smbt_engine u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_start_wr(ev_start_wr), .ev_start_rd(ev_start_rd), .ev_stop(ev_stop),
        .ev_nack(ev_nack), .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_req(rd_req),
        .tx_valid(tx_valid), .tx_byte(tx_byte),
        .be_quick(be_quick), .be_quick_rd(be_quick_rd),
        .be_send(be_send), .be_send_byte(be_send_byte),
        .be_wr(be_wr), .be_wr_cmd(be_wr_cmd), .be_wr_len(be_wr_len),
        .be_buf_idx(be_buf_idx), .be_buf_byte(be_buf_byte),
        .be_recv_req(be_recv_req), .be_recv_data(be_recv_data),
        .be_rd_req(be_rd_req), .be_rd_cmd(be_rd_cmd), .be_rd_idx(be_rd_idx),
        .be_rd_data(be_rd_data), .ovf(ovf), .confused(confused)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // No dispatch strobe visible now.
    task automatic chk_quiet(input string req);
        chk(req, "strobes", {29'd0, be_quick, be_send, be_wr}, 0);
    endtask

    // Drive one event for one cycle; return at the next falling edge.
    task automatic pulse(input int kind, input logic [7:0] b);
        case (kind)
            0: ev_start_wr = 1;
            1: ev_start_rd = 1;
            2: ev_stop = 1;
            3: ev_nack = 1;
            4: begin rx_valid = 1; rx_byte = b; end
            default: rd_req = 1;
        endcase
        @(negedge clk);
        {ev_start_wr, ev_start_rd, ev_stop, ev_nack, rx_valid, rd_req} = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R1 watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "rst outs", {26'd0, tx_valid, be_quick, be_send, be_wr, ovf, confused}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "post-rst outs", {26'd0, tx_valid, be_quick, be_send, be_wr, ovf, confused}, 0);

        // R2 R3 R4 R9: write sweep over lengths 0..37
        for (int n = 0; n <= 37; n++) begin
            int kept;
            kept = (n > 34) ? 34 : n;
            pulse(0, 8'h00);
            chk_quiet("R4");
            for (int k = 0; k < n; k++) pulse(4, pat(n, k));
            chk("R9", "ovf before stop", ovf, (n > 34) ? 1 : 0);
            chk("R8", "confused", confused, 0);
            pulse(2, 8'h00);
            chk("R9", "ovf after stop", ovf, 0);
            if (n == 0) begin
                chk("R2", "quick", be_quick, 1);
                chk("R2", "quick dir", be_quick_rd, 0);
                chk("R2", "other strobes", {be_send, be_wr}, 0);
            end else if (n == 1) begin
                chk("R3", "send", be_send, 1);
                chk("R3", "send byte", be_send_byte, pat(n, 0));
                chk("R3", "other strobes", {be_quick, be_wr}, 0);
            end else begin
                chk("R4", "wr", be_wr, 1);
                chk("R4", "wr cmd", be_wr_cmd, pat(n, 0));
                chk("R4", "wr len", be_wr_len, kept - 1);
                for (int k = 0; k < kept - 1; k++) begin
                    be_buf_idx = 8'(k);
                    #1;
                    chk("R4", "payload", be_buf_byte, pat(n, k + 1));
                end
                @(negedge clk);
            end
        end

        // R5: receive byte, then NACK in finished read is ignored (R7)
        pulse(1, 8'h00);
        rd_req = 1;
        #1 chk("R5", "recv req", be_recv_req, 1);
        @(negedge clk); rd_req = 0;
        chk("R5", "tx valid", tx_valid, 1);
        chk("R5", "tx byte", tx_byte, 8'h5A);
        pulse(3, 8'h00);
        chk("R7", "nack in done", confused, 0);
        pulse(2, 8'h00);
        chk_quiet("R5");

        // R2: read start then stop gives read-direction quick
        pulse(1, 8'h00);
        pulse(2, 8'h00);
        chk("R2", "quick rd", {be_quick, be_quick_rd}, 3);

        // R7: second read after receive-byte returns zero, no backend request
        pulse(1, 8'h00);
        pulse(5, 8'h00);
        rd_req = 1;
        #1 chk("R7", "no recv req", {be_recv_req, be_rd_req}, 0);
        @(negedge clk); rd_req = 0;
        chk("R7", "zero tx", tx_byte, 0);
        chk("R7", "confused", confused, 1);
        pulse(2, 8'h00);
        chk("R10", "recovered", confused, 0);
        chk_quiet("R10");

        // R6: combined write-then-read for 1..3 written and 1..4 read bytes
        for (int w = 1; w <= 3; w++) begin
            for (int l = 1; l <= 4; l++) begin
                logic [7:0] c;
                c = 8'(8'h40 + w * 16 + l);
                pulse(0, 8'h00);
                pulse(4, c);
                for (int k = 1; k < w; k++) pulse(4, 8'(c + k));
                pulse(1, 8'h00);
                if (w > 1) begin
                    chk("R6", "wr before read", be_wr, 1);
                    chk("R6", "wr cmd", be_wr_cmd, c);
                    chk("R6", "wr len", be_wr_len, w - 1);
                end else begin
                    chk_quiet("R6");
                end
                for (int i = 0; i < l; i++) begin
                    rd_req = 1;
                    #1;
                    chk("R6", "rd req", be_rd_req, 1);
                    chk("R6", "rd cmd", be_rd_cmd, c);
                    chk("R6", "rd idx", be_rd_idx, i);
                    @(negedge clk); rd_req = 0;
                    chk("R6", "tx byte", tx_byte, rd_fn(c, 8'(i)));
                end
                // R11: byte received during read phase is not stored
                pulse(4, 8'hEE);
                pulse(3, 8'h00);
                chk("R7", "nack ends read", confused, 0);
                pulse(5, 8'h00);
                chk("R7", "post-nack tx", tx_byte, 0);
                pulse(2, 8'h00);
                chk_quiet("R6");
            end
        end

        // R8 R10: write start outside idle; confused ignores events
        pulse(0, 8'h00);
        pulse(0, 8'h00);
        chk("R8", "double start", confused, 1);
        pulse(4, 8'h33);
        pulse(3, 8'h00);
        pulse(1, 8'h00);
        chk("R10", "still confused", confused, 1);
        chk_quiet("R10");
        pulse(5, 8'h00);
        chk("R10", "confused tx", tx_byte, 0);
        pulse(2, 8'h00);
        chk("R10", "stop recovers", confused, 0);
        chk_quiet("R10");

        // R8: read start after zero-byte write start
        pulse(0, 8'h00);
        pulse(1, 8'h00);
        chk("R8", "empty restart", confused, 1);
        pulse(2, 8'h00);

        // R7: NACK in idle and in write phase
        pulse(3, 8'h00);
        chk("R7", "nack idle", confused, 1);
        pulse(2, 8'h00);
        pulse(0, 8'h00);
        pulse(3, 8'h00);
        chk("R7", "nack write", confused, 1);
        pulse(2, 8'h00);
        chk_quiet("R7");

        // R11: byte in idle not counted
        pulse(4, 8'h77);
        pulse(0, 8'h00);
        pulse(2, 8'h00);
        chk("R11", "idle byte ignored", {be_quick, be_quick_rd, be_send}, 3'b100);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule